// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the memory micro-sequence a processor core goes through when it takes an exception or interrupt, and the reverse sequence when the handler returns. The core hands it one request: the exception index, up to `MAX_ARGS` argument words and its current stack pointer, frame pointer, instruction pointer and flags. On entry the sequencer fetches the handler address and a per-vector stack pointer from the vector table. It switches to that stack and stores the old stack pointer, the flags, the return IP and the old FP there. The last two form a linked frame, and the arguments are pushed after them. It then hands back the new register values with the privilege flag set and hardware interrupts masked. On return it pops the frame and the saved flags and stack pointer.

If entry fails because the index is out of range or because memory answers with an error, the sequencer starts again on the double-fault vector. The original index then goes in as the first argument, ahead of the original arguments. A second failure, or any failure during a return, leaves the block halted until reset. Memory is reached through a 32-bit port with one transaction in flight at a time.

Both interfaces are valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, and the core must hold the request fields stable while `req_valid` waits. On the memory side, the block keeps `mem_req_valid` and every request field stable until `mem_req_ready` accepts the request. Memory returns exactly one response per accepted request, no earlier than the cycle after acceptance. The block never refuses a response.

Top module: `exc_seq`

## Requirements
- R1: After reset `req_ready` is 1, `busy` and `done` are 0, `fault_status` is 0, `out_sp` and `out_fp` are 0, `out_ip` equals `BOOT_IP` and `out_flags` is 6'b000001. The flags word is laid out from bit 0 upward as privileged, hardware-interrupt-enable, equal, zero, overflow, sign.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. From the next cycle `busy` is 1 and `req_ready` is 0 until the sequence completes.
- R3: An entry for index i first reads the handler IP at `vec_base + 8*i` and then the handler SP at `vec_base + 8*i + 4`. Both are reads (`mem_we` = 0).
- R4: Each push decrements the working SP by 4 modulo 2^32 and then writes at the new value. The pushes on entry, in order, are: the old SP, the flags zero-extended to 32 bits, the old IP, the old FP, then each argument from index 0 upward.
- R5: When an entry completes, `out_fp` is the vector SP minus 16 and `out_sp` is `out_fp` minus 4 per argument. `out_ip` is the handler IP. `out_flags` equals the request flags with bit 0 set and bit 1 cleared.
- R6: A return pops four words from `cur_sp` upward, each read at SP followed by SP+4: FP, then IP, then flags (low 6 bits), then SP. The popped values appear on `out_fp`, `out_ip`, `out_flags` and `out_sp`, and no further words are removed.
- R7: An entry index greater than or equal to `NUM_EXC` is a fault that makes no memory access on its own behalf.
- R8: A fault during a first entry restarts entry on vector `DF_INDEX`. The stored SP, flags, IP and FP are those of the request, the arguments are the original index followed by the original arguments, and `fault_status` reads 1 (double fault) at completion.
- R9: A fault during a double-fault entry pulses `done` and sets `fault_status` to 2 (halted). The output registers keep their previous values, and `req_ready` stays 0 until reset.
- R10: A memory error response during a return halts the block in the same way as R9.
- R11: A memory request stays valid with stable address, write enable and data until accepted, and at most one transaction is outstanding.
- R12: `done` is a single-cycle pulse. In that cycle `busy` is 0 and the outputs already hold the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_return | input | 1 | 0 = exception entry, 1 = return |
| req_index | input | IDX_W | Exception index for entry |
| req_nargs | input | CNT_W | Number of argument words (saturates at MAX_ARGS) |
| req_args | input | 32*MAX_ARGS | Argument words, word 0 in the low bits |
| cur_sp | input | 32 | Current stack pointer |
| cur_fp | input | 32 | Current frame pointer |
| cur_ip | input | 32 | Return instruction pointer |
| cur_flags | input | 6 | Current flags word |
| vec_base | input | 32 | Vector table base address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_status | output | 2 | 0 none, 1 double fault, 2 halted |
| out_sp | output | 32 | Resulting stack pointer |
| out_fp | output | 32 | Resulting frame pointer |
| out_ip | output | 32 | Resulting instruction pointer |
| out_flags | output | 6 | Resulting flags word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Response carries an access fault |
| mem_rdata | input | 32 | Read data |

## Verification
A corrupted working SP or step counter shows on the memory port at once: the next request carries a wrong address, a wrong write value or a read where a write belongs. The scoreboard compares every accepted memory request against the predicted order, so such a fault is caught within one transaction of occurring. A wrong captured flags, FP or handler word stays hidden until `done`, where it appears on the output registers, or until the following return pops it back. Errors in the fault path show up as a different vector address in the request right after the failing response, or as a `fault_status` that does not match.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int WORD_W  = 32;
  localparam int FLAG_W  = 6;
  localparam int FLG_PRIV = 0;
  localparam int FLG_HWI  = 1;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_RUN,
    CS_HALT
  } ctl_e;

  typedef enum logic [3:0] {
    ST_VEC_IP,
    ST_VEC_SP,
    ST_SAVE_SP,
    ST_SAVE_FLG,
    ST_SAVE_IP,
    ST_SAVE_FP,
    ST_ARGS,
    ST_LD_FP,
    ST_LD_IP,
    ST_LD_FLG,
    ST_LD_SP
  } step_e;

  typedef enum logic [1:0] {
    FS_NONE   = 2'd0,
    FS_DOUBLE = 2'd1,
    FS_HALT   = 2'd2
  } fstat_e;

endpackage

// File: rtl/exc_mem_port.sv
module exc_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          op_done,
  output logic          op_err,
  output logic [DW-1:0] op_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [DW-1:0] mem_rdata
);

  logic vld_q;
  logic wait_q;

  // one transaction at a time: offer, then wait for its single response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      wait_q    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (vld_q) begin
      if (mem_req_ready) begin
        vld_q  <= 1'b0;
        wait_q <= 1'b1;
      end
    end else if (wait_q) begin
      if (mem_rsp_valid) wait_q <= 1'b0;
    end else if (start) begin
      vld_q     <= 1'b1;
      mem_we    <= we;
      mem_addr  <= addr;
      mem_wdata <= wdata;
    end
  end

  assign mem_req_valid = vld_q;
  assign op_done       = wait_q && mem_rsp_valid;
  assign op_err        = op_done && mem_rsp_err;
  assign op_rdata      = mem_rdata;

endmodule

// File: rtl/exc_arg_buf.sv
module exc_arg_buf #(
  parameter int MAX_ARGS = 2,
  parameter int DW       = 32,
  parameter int CNT_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [MAX_ARGS*DW-1:0] load_args,
  input  logic [CNT_W-1:0]       load_cnt,
  input  logic                   prepend,
  input  logic [DW-1:0]          prep_word,
  input  logic [CNT_W-1:0]       sel,
  output logic [DW-1:0]          rd_word,
  output logic [CNT_W-1:0]       count
);

  localparam int              N_SLOT = MAX_ARGS + 1;
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(MAX_ARGS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(N_SLOT - 1);

  logic [DW-1:0] slot [N_SLOT];

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[i] <= '0;
      end else if (load) begin
        if (i < MAX_ARGS) slot[i] <= load_args[i*DW +: DW];
        else              slot[i] <= '0;
      end else if (prepend) begin
        if (i == 0) slot[i] <= prep_word;
        else        slot[i] <= slot[(i > 0) ? i-1 : 0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= (load_cnt > CAP) ? CAP : load_cnt;
    else if (prepend) count <= count + CNT_W'(1);
  end

  assign rd_word = (sel <= LAST) ? slot[sel] : '0;

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int          IDX_W    = 8,
  parameter int          NUM_EXC  = 16,
  parameter int          DF_INDEX = 2,
  parameter int          MAX_ARGS = 2,
  parameter logic [31:0] BOOT_IP  = 32'h0000_0100,
  parameter int          CNT_W    = $clog2(MAX_ARGS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_return,
  input  logic [IDX_W-1:0]       req_index,
  input  logic [CNT_W-1:0]       req_nargs,
  input  logic [32*MAX_ARGS-1:0] req_args,
  input  logic [31:0]            cur_sp,
  input  logic [31:0]            cur_fp,
  input  logic [31:0]            cur_ip,
  input  logic [5:0]             cur_flags,
  input  logic [31:0]            vec_base,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             fault_status,
  output logic [31:0]            out_sp,
  output logic [31:0]            out_fp,
  output logic [31:0]            out_ip,
  output logic [5:0]             out_flags,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_we,
  output logic [31:0]            mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_rsp_valid,
  input  logic                   mem_rsp_err,
  input  logic [31:0]            mem_rdata
);

  localparam logic [31:0]       NUM_EXC_W = 32'(NUM_EXC);
  localparam logic [IDX_W-1:0]  DF_IDX    = IDX_W'(DF_INDEX);
  localparam logic [FLAG_W-1:0] FLG_RST   = FLAG_W'(1);
  localparam logic [31:0]       WSTEP     = 32'd4;

  ctl_e               ctl;
  step_e              step;
  logic               issued, is_ret, in_df;
  logic [IDX_W-1:0]   idx_q;
  logic [31:0]        base_q, osp_q, ofp_q, oip_q, hip_q, fp_new, sp_w;
  logic [FLAG_W-1:0]  oflg_q, ent_flg;
  logic [CNT_W-1:0]   arg_sel, arg_cnt;
  logic [1:0]         status_q;
  logic               done_q;

  logic               accept, start, fault, last_push, prepend;
  logic               op_we, op_done, op_err;
  logic [31:0]        op_addr, op_wdata, op_rdata, arg_word;
  logic [31:0]        idx_ext, vec_addr, push_addr;
  logic               bad_idx;

  assign accept    = (ctl == CS_IDLE) && req_valid;
  assign idx_ext   = {{(32-IDX_W){1'b0}}, idx_q};
  assign vec_addr  = base_q + (idx_ext << 3);
  assign bad_idx   = idx_ext >= NUM_EXC_W;
  assign push_addr = sp_w - WSTEP;

  // address, direction and data of the memory step now due
  always_comb begin
    op_we    = 1'b0;
    op_addr  = sp_w;
    op_wdata = '0;
    unique case (step)
      ST_VEC_IP:   op_addr = vec_addr;
      ST_VEC_SP:   op_addr = vec_addr + WSTEP;
      ST_SAVE_SP:  begin op_we = 1'b1; op_addr = push_addr; op_wdata = osp_q; end
      ST_SAVE_FLG: begin op_we = 1'b1; op_addr = push_addr; op_wdata = {{(32-FLAG_W){1'b0}}, oflg_q}; end
      ST_SAVE_IP:  begin op_we = 1'b1; op_addr = push_addr; op_wdata = oip_q; end
      ST_SAVE_FP:  begin op_we = 1'b1; op_addr = push_addr; op_wdata = ofp_q; end
      ST_ARGS:     begin op_we = 1'b1; op_addr = push_addr; op_wdata = arg_word; end
      default:     op_addr = sp_w;
    endcase
  end

  always_comb begin
    ent_flg           = oflg_q;
    ent_flg[FLG_PRIV] = 1'b1;
    ent_flg[FLG_HWI]  = 1'b0;
  end

  assign start     = (ctl == CS_RUN) && !issued && !((step == ST_VEC_IP) && bad_idx);
  assign fault     = (ctl == CS_RUN) &&
                     ((!issued && (step == ST_VEC_IP) && bad_idx) || op_err);
  assign prepend   = fault && !is_ret && !in_df;
  assign last_push = op_done && !op_err &&
                     (((step == ST_SAVE_FP) && (arg_cnt == '0)) ||
                      ((step == ST_ARGS) && (arg_sel + CNT_W'(1) == arg_cnt)));

  exc_mem_port #(.AW(32), .DW(32)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .we            (op_we),
    .addr          (op_addr),
    .wdata         (op_wdata),
    .op_done       (op_done),
    .op_err        (op_err),
    .op_rdata      (op_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rdata     (mem_rdata)
  );

  exc_arg_buf #(.MAX_ARGS(MAX_ARGS), .DW(32), .CNT_W(CNT_W)) u_args (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_args (req_args),
    .load_cnt  (req_nargs),
    .prepend   (prepend),
    .prep_word (idx_ext),
    .sel       (arg_sel),
    .rd_word   (arg_word),
    .count     (arg_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= CS_IDLE;
      step      <= ST_VEC_IP;
      issued    <= 1'b0;
      is_ret    <= 1'b0;
      in_df     <= 1'b0;
      idx_q     <= '0;
      base_q    <= '0;
      osp_q     <= '0;
      ofp_q     <= '0;
      oip_q     <= '0;
      oflg_q    <= '0;
      hip_q     <= '0;
      fp_new    <= '0;
      sp_w      <= '0;
      arg_sel   <= '0;
      status_q  <= FS_NONE;
      done_q    <= 1'b0;
      out_sp    <= '0;
      out_fp    <= '0;
      out_ip    <= BOOT_IP;
      out_flags <= FLG_RST;
    end else begin
      done_q <= 1'b0;
      unique case (ctl)
        CS_IDLE: if (req_valid) begin
          ctl      <= CS_RUN;
          step     <= req_return ? ST_LD_FP : ST_VEC_IP;
          issued   <= 1'b0;
          is_ret   <= req_return;
          in_df    <= 1'b0;
          idx_q    <= req_index;
          base_q   <= vec_base;
          osp_q    <= cur_sp;
          ofp_q    <= cur_fp;
          oip_q    <= cur_ip;
          oflg_q   <= cur_flags;
          sp_w     <= cur_sp;
          arg_sel  <= '0;
          status_q <= FS_NONE;
        end
        CS_RUN: if (fault) begin
          issued <= 1'b0;
          if (is_ret || in_df) begin
            ctl      <= CS_HALT;
            status_q <= FS_HALT;
            done_q   <= 1'b1;
          end else begin
            // restart on the double-fault vector with the original state
            in_df    <= 1'b1;
            idx_q    <= DF_IDX;
            step     <= ST_VEC_IP;
            arg_sel  <= '0;
            status_q <= FS_DOUBLE;
          end
        end else begin
          if (start) issued <= 1'b1;
          if (op_done) begin
            issued <= 1'b0;
            unique case (step)
              ST_VEC_IP:   begin hip_q <= op_rdata; step <= ST_VEC_SP; end
              ST_VEC_SP:   begin sp_w <= op_rdata;  step <= ST_SAVE_SP; end
              ST_SAVE_SP:  begin sp_w <= push_addr; step <= ST_SAVE_FLG; end
              ST_SAVE_FLG: begin sp_w <= push_addr; step <= ST_SAVE_IP; end
              ST_SAVE_IP:  begin sp_w <= push_addr; step <= ST_SAVE_FP; end
              ST_SAVE_FP:  begin
                sp_w   <= push_addr;
                fp_new <= push_addr;
                step   <= ST_ARGS;
              end
              ST_ARGS:     begin sp_w <= push_addr; arg_sel <= arg_sel + CNT_W'(1); end
              ST_LD_FP:    begin ofp_q <= op_rdata; sp_w <= sp_w + WSTEP; step <= ST_LD_IP; end
              ST_LD_IP:    begin oip_q <= op_rdata; sp_w <= sp_w + WSTEP; step <= ST_LD_FLG; end
              ST_LD_FLG:   begin oflg_q <= op_rdata[FLAG_W-1:0]; sp_w <= sp_w + WSTEP; step <= ST_LD_SP; end
              ST_LD_SP:    begin
                out_sp    <= op_rdata;
                out_fp    <= ofp_q;
                out_ip    <= oip_q;
                out_flags <= oflg_q;
                done_q    <= 1'b1;
                ctl       <= CS_IDLE;
              end
              default: ;
            endcase
            if (last_push) begin
              out_sp    <= push_addr;
              out_fp    <= (step == ST_SAVE_FP) ? push_addr : fp_new;
              out_ip    <= hip_q;
              out_flags <= ent_flg;
              done_q    <= 1'b1;
              ctl       <= CS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready    = (ctl == CS_IDLE);
  assign busy         = (ctl == CS_RUN);
  assign done         = done_q;
  assign fault_status = status_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_return,
  input logic        busy,
  input logic        done,
  input logic [1:0]  fault_status,
  input logic [5:0]  out_flags,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);

  logic kind_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) kind_ret <= 1'b0;
    else if (req_valid && req_ready) kind_ret <= req_return;
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
                                        && $stable(mem_we) && $stable(mem_wdata));

  a_r11_req_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_status == 2'd2 |=> fault_status == 2'd2 && !req_ready && !busy);

  a_r5_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done && !kind_ret && fault_status != 2'd2 |-> out_flags[0] && !out_flags[1]);

endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_return    (req_return),
  .busy          (busy),
  .done          (done),
  .fault_status  (fault_status),
  .out_flags     (out_flags),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata)
);

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
module sim_exc_seq;

  localparam int          IDX_W = 8;
  localparam int          NEXC  = 16;
  localparam int          DFI   = 2;
  localparam int          MAXA  = 2;
  localparam int          CW    = 2;
  localparam logic [31:0] BOOT  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_return = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic [CW-1:0] req_nargs = '0;
  logic [32*MAXA-1:0] req_args = '0;
  logic [31:0] cur_sp = '0, cur_fp = '0, cur_ip = '0, vec_base = '0;
  logic [5:0] cur_flags = '0;
  logic req_ready, busy, done;
  logic [1:0] fault_status;
  logic [31:0] out_sp, out_fp, out_ip;
  logic [5:0] out_flags;
  logic mem_req_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  exc_seq #(.IDX_W(IDX_W), .NUM_EXC(NEXC), .DF_INDEX(DFI), .MAX_ARGS(MAXA),
            .BOOT_IP(BOOT), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_return(req_return), .req_index(req_index), .req_nargs(req_nargs),
    .req_args(req_args), .cur_sp(cur_sp), .cur_fp(cur_fp), .cur_ip(cur_ip),
    .cur_flags(cur_flags), .vec_base(vec_base), .busy(busy), .done(done),
    .fault_status(fault_status), .out_sp(out_sp), .out_fp(out_fp),
    .out_ip(out_ip), .out_flags(out_flags), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata));

  int checks = 0;
  int errors = 0;
  logic [31:0] mem_model [logic [31:0]];
  logic [64:0] exp_q [$];
  logic [31:0] err_addr = '0;
  int          err_left = 0;
  bit          bp_mode = 1'b0;
  int          cyc = 0;
  bit          pend = 1'b0, pend_err = 1'b0, prev_stall = 1'b0;
  logic [31:0] pend_data = '0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  // memory model and scoreboard monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
    end else if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_err   = pend_err;
      mem_rdata     = pend_data;
      pend          = 1'b0;
    end
    if (prev_stall) chk("R11 request held", {31'b0, mem_req_valid}, 32'd1);
    mem_req_ready = bp_mode ? ((cyc % 3) != 1) : 1'b1;
    prev_stall = mem_req_valid && !mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      logic [64:0] e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected access actual=%h_%h expected=none", mem_addr, mem_wdata);
      end else begin
        e = exp_q.pop_front();
        if (e[64] !== mem_we || e[63:32] !== mem_addr || (e[64] && e[31:0] !== mem_wdata)) begin
          errors++;
          $display("FAIL R3/R4 access actual=%b_%h_%h expected=%b_%h_%h",
                   mem_we, mem_addr, mem_wdata, e[64], e[63:32], e[31:0]);
        end
      end
      pend     = 1'b1;
      pend_err = (err_left > 0) && (mem_addr == err_addr);
      if (pend_err) err_left--;
      else if (mem_we) mem_model[mem_addr] = mem_wdata;
      pend_data = mem_we ? 32'h0 : rd(mem_addr);
    end
  end

  task automatic exp_acc(input logic w, input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({w, a, d});
  endtask

  // driver side: predicted accesses of one complete entry
  task automatic exp_entry(input logic [31:0] base, input int idx,
                           input logic [31:0] osp, ofp, oip, input logic [5:0] oflg,
                           input int n, input logic [31:0] w0, w1, w2,
                           output logic [31:0] fp_o, output logic [31:0] sp_o);
    logic [31:0] va, s;
    logic [31:0] w [3];
    w[0] = w0; w[1] = w1; w[2] = w2;
    va = base + 32'(idx) * 32'd8;
    exp_acc(1'b0, va, 32'h0);
    exp_acc(1'b0, va + 32'd4, 32'h0);
    s = rd(va + 32'd4);
    s = s - 32'd4; exp_acc(1'b1, s, osp);
    s = s - 32'd4; exp_acc(1'b1, s, {26'b0, oflg});
    s = s - 32'd4; exp_acc(1'b1, s, oip);
    s = s - 32'd4; exp_acc(1'b1, s, ofp);
    fp_o = s;
    for (int k = 0; k < n; k++) begin
      s = s - 32'd4; exp_acc(1'b1, s, w[k]);
    end
    sp_o = s;
  endtask

  task automatic do_req(input logic ret, input int idx, input int n,
                        input logic [31:0] a0, a1, sp, fp, ip,
                        input logic [5:0] flg, input logic [31:0] base);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_return = ret; req_index = IDX_W'(idx);
    req_nargs = CW'(n); req_args = {a1, a0};
    cur_sp = sp; cur_fp = fp; cur_ip = ip; cur_flags = flg; vec_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", {30'b0, busy, req_ready}, 32'd2);
    t = 0;
    while (done !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk("R12 done seen", {31'b0, done}, 32'd1);
    chk("R12 busy low at done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R12 done one cycle", {31'b0, done}, 32'd0);
    chk("R4 scoreboard drained", exp_q.size(), 32'd0);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 busy/done", {30'b0, busy, done}, 32'd0);
    chk("R1 status", {30'b0, fault_status}, 32'd0);
    chk("R1 sp", out_sp, 32'h0);
    chk("R1 fp", out_fp, 32'h0);
    chk("R1 ip", out_ip, BOOT);
    chk("R1 flags", {26'b0, out_flags}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] efp, esp;
    mem_model[32'h18]   = 32'h0000_4000;  // vector 3
    mem_model[32'h1C]   = 32'h0000_8000;
    mem_model[32'h10]   = 32'h0000_5000;  // vector 2 (double fault)
    mem_model[32'h14]   = 32'h0000_9000;
    mem_model[32'h1028] = 32'h0000_6000;  // vector 5 at base 0x1000
    mem_model[32'h102C] = 32'h0000_0008;
    reset_dut();

    // R3 R4 R5: plain entry, two arguments
    exp_entry(32'h0, 3, 32'h7000, 32'h7010, 32'h300, 6'b111110, 2,
              32'hA1, 32'hB2, 32'h0, efp, esp);
    do_req(1'b0, 3, 2, 32'hA1, 32'hB2, 32'h7000, 32'h7010, 32'h300, 6'b111110, 32'h0);
    chk("R5 fp", out_fp, 32'h7FF0);
    chk("R5 sp", out_sp, 32'h7FE8);
    chk("R5 ip", out_ip, 32'h4000);
    chk("R5 flags", {26'b0, out_flags}, 32'h3D);
    chk("R5 status", {30'b0, fault_status}, 32'd0);

    // R6 return under memory back-pressure (R11)
    bp_mode = 1'b1;
    exp_acc(1'b0, 32'h7FF0, 0); exp_acc(1'b0, 32'h7FF4, 0);
    exp_acc(1'b0, 32'h7FF8, 0); exp_acc(1'b0, 32'h7FFC, 0);
    do_req(1'b1, 0, 0, 0, 0, 32'h7FF0, 32'hDEAD, 32'hBEEF, 6'b0, 32'h0);
    chk("R6 fp", out_fp, 32'h7010);
    chk("R6 ip", out_ip, 32'h300);
    chk("R6 flags", {26'b0, out_flags}, 32'h3E);
    chk("R6 sp", out_sp, 32'h7000);

    // R4 wrap below zero, nonzero base, no arguments
    exp_entry(32'h1000, 5, 32'h2000, 32'h2010, 32'h444, 6'b000011, 0,
              0, 0, 0, efp, esp);
    do_req(1'b0, 5, 0, 0, 0, 32'h2000, 32'h2010, 32'h444, 6'b000011, 32'h1000);
    chk("R4 wrapped fp", out_fp, 32'hFFFF_FFF8);
    chk("R5 sp equals fp", out_sp, 32'hFFFF_FFF8);
    chk("R5 flags wrap case", {26'b0, out_flags}, 32'h1);
    bp_mode = 1'b0;

    // R7 invalid index goes straight to the double-fault vector
    exp_entry(32'h0, DFI, 32'h3000, 32'h3010, 32'h500, 6'b000110, 2,
              32'd16, 32'hC3, 0, efp, esp);
    do_req(1'b0, 16, 1, 32'hC3, 0, 32'h3000, 32'h3010, 32'h500, 6'b000110, 32'h0);
    chk("R7 status double", {30'b0, fault_status}, 32'd1);
    chk("R7 handler ip", out_ip, 32'h5000);
    chk("R8 fp", out_fp, 32'h8FF0);
    chk("R8 sp", out_sp, 32'h8FE8);

    // R8 memory error on vector SP read restarts with index first
    err_addr = 32'h1C; err_left = 1;
    exp_acc(1'b0, 32'h18, 0); exp_acc(1'b0, 32'h1C, 0);
    exp_entry(32'h0, DFI, 32'h6000, 32'h6010, 32'h600, 6'b100000, 3,
              32'd3, 32'hD1, 32'hD2, efp, esp);
    do_req(1'b0, 3, 2, 32'hD1, 32'hD2, 32'h6000, 32'h6010, 32'h600, 6'b100000, 32'h0);
    chk("R8 status double", {30'b0, fault_status}, 32'd1);
    chk("R8 sp three args", out_sp, 32'h8FE4);
    chk("R8 flags", {26'b0, out_flags}, 32'h21);

    // R9 fault inside double-fault entry halts
    err_addr = 32'h10; err_left = 1;
    exp_acc(1'b0, 32'h10, 0);
    do_req(1'b0, 20, 0, 0, 0, 32'h1234, 32'h5678, 32'h9ABC, 6'b0, 32'h0);
    chk("R9 status halt", {30'b0, fault_status}, 32'd2);
    chk("R9 sp unchanged", out_sp, 32'h8FE4);
    chk("R9 ip unchanged", out_ip, 32'h5000);
    repeat (5) @(negedge clk);
    chk("R9 ready held low", {31'b0, req_ready}, 32'd0);
    reset_dut();

    // R10 memory error during return halts
    err_addr = 32'h7FF4; err_left = 1;
    exp_acc(1'b0, 32'h7FF0, 0); exp_acc(1'b0, 32'h7FF4, 0);
    do_req(1'b1, 0, 0, 0, 0, 32'h7FF0, 0, 0, 6'b0, 32'h0);
    chk("R10 status halt", {30'b0, fault_status}, 32'd2);
    chk("R10 ip unchanged", out_ip, BOOT);
    chk("R10 ready low", {31'b0, req_ready}, 32'd0);
    reset_dut();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule